// File: doc/BRIEF.md
# Instruction Machine-Cycle Sequencer

This block sets the timing of every instruction in an 8-bit accumulator processor. Each instruction is split into numbered bus cycles, one to five of them, and each cycle is split into clock states. Every instruction begins with an opcode fetch. After the fetch, the block works out from the latched opcode how many further cycles the instruction needs. It also works out the kind of bus transfer each cycle performs and which address register drives the bus during that cycle. The cycle number, state number, cycle kind and address source appear on the ports so that the bus unit and the datapath can follow them.

The sequencer holds the address registers it controls itself:
- the program counter;
- the temporary address pair, with a high byte and a low byte;
- the stack pointer.

Operand bytes of an instruction are captured into the temporary pair. A condition input, sampled during the fetch, decides two things:
- whether a conditional jump, call or return loads the program counter;
- whether a conditional call or return keeps its stack cycles.

A halt instruction parks the sequencer until reset. Arithmetic, wait states and interrupts belong to other blocks.

Top module: `msq_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to cycle 1 / state 1. At the same edge `pc`, `wz` and `sp` become 0, and `halted` and `done` become 0.
- R2: Every instruction starts with cycle 1, of kind fetch, with address source PC. In that cycle, `pc` increments after state 2 and `din` is latched as the opcode in state 3. Kind codes on `ctype`: 0 fetch, 1 memory read, 2 memory write, 3 stack read, 4 stack write, 5 I/O read, 6 I/O write, 7 halt. Source codes on `asrc`: 0 PC, 1 HL pair, 2 temporary pair, 3 SP.
- R3: Cycle 1 lasts 5 states for the following opcodes, and 4 states for all others:
  - a register-to-register move (01dddsss, neither field 110);
  - call;
  - conditional call;
  - conditional return;
  - restart.
  Every later cycle lasts 3 states.
- R4: The moves that use memory behave as follows:
  - 01ddd110 adds one memory read from HL;
  - 01110sss adds one memory write to HL;
  - 00110110 reads an immediate byte from PC and then writes to HL.
- R5: An operand cycle has source PC and increments `pc` after state 2. In that state it latches `din`: the second instruction byte goes to the low half of `wz`, and the third goes to the high half. For port input (11011011) and port output (11010011), the single operand byte is copied into both halves. The third cycle of these is an I/O read or write at the temporary pair.
- R6: Direct accumulator load (00111010) and store (00110010) take four cycles: fetch, two operand reads, then a memory read or write at the temporary pair.
- R7: Jump (11000011) and conditional jump (11ccc010) always take three cycles. At the end, `pc` takes `wz` if the jump is unconditional or the condition was true. Otherwise `pc` is left pointing past the operands.
- R8: Call (11001101) decrements `sp` in state 4 of cycle 1. It reads two operand bytes and then makes two stack writes at `sp`, in cycles 4 and 5. `sp` is decremented again in state 2 of cycle 4. The call ends with `pc` equal to `wz` and `sp` two below its start value.
- R9: Conditional call (11ccc100) samples `cond_ok` in state 4 of cycle 1. If it is false, the instruction ends after its three cycles with `sp` unchanged. If it is true, the instruction behaves as in R8.
- R10: Return (11001001) makes two stack reads at `sp`, incrementing `sp` in state 2 of each. The first byte goes to the low half of `wz` and the second to the high half, and `pc` then takes `wz`. Conditional return (11ccc000) does the same when the condition is true. When the condition is false it ends after its 5-state cycle 1.
- R11: Restart (11nnn111) decrements `sp` in state 4 of cycle 1. It then makes two stack writes, with a second decrement in state 2 of the first write. It loads `wz` with 0000_0000_00nn_n000 and ends with `pc` equal to that value.
- R12: Halt (01110110) has a second cycle of kind halt with source PC. After that cycle, `halted` is 1. The block stays at cycle 1 / state 1 with `pc` unchanged and `done` low until reset.
- R13: `done` is high for exactly the last state of each instruction. At the next edge the block is at cycle 1 / state 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Data bus in: opcode in cycle 1, operand or stack byte in later cycles |
| cond_ok | input | 1 | Branch condition result, sampled in cycle 1 state 4 |
| mcyc | output | 3 | Current cycle number, 1 to 5 |
| tst | output | 3 | Current state number, 1 to 5 |
| ctype | output | 3 | Kind of the current cycle (codes in R2) |
| asrc | output | 2 | Address source of the current cycle (codes in R2) |
| pc | output | 16 | Program counter |
| wz | output | 16 | Temporary address pair, high byte above low byte |
| sp | output | 16 | Stack pointer |
| done | output | 1 | High in the last state of an instruction |
| halted | output | 1 | High once halt mode has been entered |

## Verification
The directed tests look first at the condition-dependent lengths:
- A conditional call with a false condition must stop after three cycles and leave `sp` alone. A design that decremented `sp` regardless would leave it two below its start value.
- A false conditional return must end after its single long fetch. A design that ignored the sampled condition would run two extra stack reads.

Conditional jumps run both ways, checking that the operand bytes are still consumed when the jump is not taken. Any design that skipped them would leave `pc` one or two bytes short. The operand-byte order is checked for immediates, returns and port addresses, where a swapped latch shows up as a byte-reversed `wz`. Restart's vector computation is checked too. Finally, the halt run confirms that the program counter stops moving and that `done` stays low; a design that kept stepping would drift `pc` on every fetch.

// File: rtl/msq_pkg.sv
package msq_pkg;
  localparam int DW = 8;
  localparam int AW = 2 * DW;
  localparam int MAX_CYC = 5;
  localparam int CW = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {
    CT_FETCH = 3'd0, CT_MRD = 3'd1, CT_MWR = 3'd2, CT_SRD = 3'd3,
    CT_SWR = 3'd4, CT_IORD = 3'd5, CT_IOWR = 3'd6, CT_HALT = 3'd7
  } cyc_t;

  typedef enum logic [1:0] {AS_PC = 2'd0, AS_HL = 2'd1, AS_WZ = 2'd2, AS_SP = 2'd3} src_t;
  typedef enum logic [1:0] {SP_HOLD, SP_INC, SP_DEC} spop_t;
  typedef enum logic [2:0] {LT_NONE, LT_Z, LT_W, LT_ZW, LT_RST} lat_t;

  typedef enum logic [4:0] {
    K_NOP, K_MOVRR, K_MOVRM, K_MOVMR, K_HLT, K_MVIR, K_MVIM, K_LDA, K_STA,
    K_JMP, K_JCC, K_CALL, K_CCC, K_RET, K_RCC, K_RST, K_IN, K_OUT
  } kind_t;

  typedef struct packed {
    cyc_t         ctype;
    src_t         src;
    lat_t         lat;
    spop_t        sp;
    logic         pc_inc;
    logic [CW-1:0] nst;
  } cdesc_t;

  function automatic kind_t classify(input logic [DW-1:0] op);
    kind_t k;
    casez (op)
      8'b01110110: k = K_HLT;
      8'b01110???: k = K_MOVMR;
      8'b01???110: k = K_MOVRM;
      8'b01??????: k = K_MOVRR;
      8'b00110110: k = K_MVIM;
      8'b00???110: k = K_MVIR;
      8'b00111010: k = K_LDA;
      8'b00110010: k = K_STA;
      8'b11000011: k = K_JMP;
      8'b11001101: k = K_CALL;
      8'b11001001: k = K_RET;
      8'b11011011: k = K_IN;
      8'b11010011: k = K_OUT;
      8'b11???010: k = K_JCC;
      8'b11???100: k = K_CCC;
      8'b11???000: k = K_RCC;
      8'b11???111: k = K_RST;
      default:     k = K_NOP;
    endcase
    return k;
  endfunction

  function automatic logic [AW-1:0] rst_vector(input logic [DW-1:0] op);
    return {{(AW-6){1'b0}}, op[5:3], 3'b000};
  endfunction

  function automatic logic [CW-1:0] cycles_of(input kind_t k, input logic c);
    logic [CW-1:0] n;
    case (k)
      K_MOVRM, K_MOVMR, K_HLT, K_MVIR: n = 3'd2;
      K_MVIM, K_JMP, K_JCC, K_IN, K_OUT, K_RST, K_RET: n = 3'd3;
      K_RCC:        n = c ? 3'd3 : 3'd1;
      K_LDA, K_STA: n = 3'd4;
      K_CALL:       n = 3'd5;
      K_CCC:        n = c ? 3'd5 : 3'd3;
      default:      n = 3'd1;
    endcase
    return n;
  endfunction

  function automatic logic jumps(input kind_t k, input logic c);
    logic j;
    case (k)
      K_JMP, K_CALL, K_RET, K_RST: j = 1'b1;
      K_JCC, K_CCC, K_RCC:         j = c;
      default:                     j = 1'b0;
    endcase
    return j;
  endfunction
endpackage

// File: rtl/msq_decode.sv
module msq_decode
  import msq_pkg::*;
(
  input  logic [DW-1:0] ir,
  input  logic [CW-1:0] mcyc,
  input  logic          cond_live,
  input  logic          cond_q,
  output cdesc_t        desc,
  output logic [CW-1:0] ncyc,
  output logic          jump,
  output kind_t         kind
);
  function automatic cdesc_t mk(input cyc_t t, input src_t s, input lat_t l,
                                input spop_t p, input logic inc, input logic [CW-1:0] n);
    cdesc_t d;
    d.ctype = t; d.src = s; d.lat = l; d.sp = p; d.pc_inc = inc; d.nst = n;
    return d;
  endfunction

  function automatic cdesc_t describe(input kind_t k, input logic [CW-1:0] m, input logic c);
    cdesc_t d;
    d = mk(CT_FETCH, AS_PC, LT_NONE, SP_HOLD, 1'b0, 3'd3);
    case (m)
      3'd1: d = mk(CT_FETCH, AS_PC, LT_NONE,
                   (k == K_CALL || k == K_RST || (k == K_CCC && c)) ? SP_DEC : SP_HOLD, 1'b1,
                   (k == K_MOVRR || k == K_CALL || k == K_CCC || k == K_RCC || k == K_RST) ? 3'd5 : 3'd4);
      3'd2: case (k)
        K_MOVRM:      d = mk(CT_MRD,  AS_HL, LT_NONE, SP_HOLD, 1'b0, 3'd3);
        K_MOVMR:      d = mk(CT_MWR,  AS_HL, LT_NONE, SP_HOLD, 1'b0, 3'd3);
        K_HLT:        d = mk(CT_HALT, AS_PC, LT_NONE, SP_HOLD, 1'b0, 3'd3);
        K_IN, K_OUT:  d = mk(CT_MRD,  AS_PC, LT_ZW,   SP_HOLD, 1'b1, 3'd3);
        K_RET, K_RCC: d = mk(CT_SRD,  AS_SP, LT_Z,    SP_INC,  1'b0, 3'd3);
        K_RST:        d = mk(CT_SWR,  AS_SP, LT_NONE, SP_DEC,  1'b0, 3'd3);
        default:      d = mk(CT_MRD,  AS_PC, LT_Z,    SP_HOLD, 1'b1, 3'd3);
      endcase
      3'd3: case (k)
        K_MVIM:       d = mk(CT_MWR,  AS_HL, LT_NONE, SP_HOLD, 1'b0, 3'd3);
        K_IN:         d = mk(CT_IORD, AS_WZ, LT_NONE, SP_HOLD, 1'b0, 3'd3);
        K_OUT:        d = mk(CT_IOWR, AS_WZ, LT_NONE, SP_HOLD, 1'b0, 3'd3);
        K_RET, K_RCC: d = mk(CT_SRD,  AS_SP, LT_W,    SP_INC,  1'b0, 3'd3);
        K_RST:        d = mk(CT_SWR,  AS_SP, LT_RST,  SP_HOLD, 1'b0, 3'd3);
        default:      d = mk(CT_MRD,  AS_PC, LT_W,    SP_HOLD, 1'b1, 3'd3);
      endcase
      3'd4: case (k)
        K_LDA:        d = mk(CT_MRD,  AS_WZ, LT_NONE, SP_HOLD, 1'b0, 3'd3);
        K_STA:        d = mk(CT_MWR,  AS_WZ, LT_NONE, SP_HOLD, 1'b0, 3'd3);
        default:      d = mk(CT_SWR,  AS_SP, LT_NONE, SP_DEC,  1'b0, 3'd3);
      endcase
      3'd5:           d = mk(CT_SWR,  AS_SP, LT_NONE, SP_HOLD, 1'b0, 3'd3);
      default: ;
    endcase
    return d;
  endfunction

  always_comb begin
    kind = classify(ir);
    desc = describe(kind, mcyc, cond_live);
    ncyc = cycles_of(kind, cond_q);
    jump = jumps(kind, cond_q);
  end
endmodule

// File: rtl/msq_regs.sv
module msq_regs
  import msq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] ir,
  input  logic          pc_inc,
  input  lat_t          lat,
  input  spop_t         spop,
  input  logic          jump,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] wz,
  output logic [AW-1:0] sp
);
  logic [DW-1:0] w_q, z_q;
  logic [AW-1:0] pc_q, sp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0; sp_q <= '0; w_q <= '0; z_q <= '0;
    end else begin
      if (jump)        pc_q <= {w_q, z_q};
      else if (pc_inc) pc_q <= pc_q + 1'b1;
      case (lat)
        LT_Z:   z_q <= din;
        LT_W:   w_q <= din;
        LT_ZW:  begin z_q <= din; w_q <= din; end
        LT_RST: {w_q, z_q} <= rst_vector(ir);
        default: ;
      endcase
      case (spop)
        SP_INC:  sp_q <= sp_q + 1'b1;
        SP_DEC:  sp_q <= sp_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign pc = pc_q;
  assign wz = {w_q, z_q};
  assign sp = sp_q;

  // R7: a taken transfer lands exactly on the temporary pair
  p_jump_target_r7: assert property (@(posedge clk) disable iff (rst)
    jump |=> pc == $past(wz));
  // R11: the restart vector leaves the high byte clear
  p_rst_vec_r11: assert property (@(posedge clk) disable iff (rst)
    (lat == LT_RST) |=> wz[AW-1:6] == '0);
endmodule

// File: rtl/msq_sequencer.sv
module msq_sequencer
  import msq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic          cond_ok,
  output logic [CW-1:0] mcyc,
  output logic [CW-1:0] tst,
  output logic [2:0]    ctype,
  output logic [1:0]    asrc,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] wz,
  output logic [AW-1:0] sp,
  output logic          done,
  output logic          halted
);
  logic [CW-1:0] mcyc_q, tst_q, ncyc;
  logic [DW-1:0] ir_q;
  logic          cond_q, halted_q, take_jump;
  cdesc_t        desc;
  kind_t         kind;

  // internal events, named for the assertions
  logic last_state, last_cyc, pc_inc_now, jump_now;
  lat_t  lat_now;
  spop_t sp_now;

  msq_decode u_dec (
    .ir(ir_q), .mcyc(mcyc_q), .cond_live(cond_ok), .cond_q(cond_q),
    .desc(desc), .ncyc(ncyc), .jump(take_jump), .kind(kind)
  );

  always_comb begin
    last_state = (tst_q == desc.nst);
    last_cyc   = (mcyc_q == ncyc);
    done       = !halted_q && last_state && last_cyc;
    pc_inc_now = !halted_q && desc.pc_inc && (tst_q == 3'd2);
    jump_now   = done && take_jump;
    lat_now    = (!halted_q && tst_q == 3'd2) ? desc.lat : LT_NONE;
    if (halted_q)
      sp_now = SP_HOLD;
    else if (mcyc_q == 3'd1)
      sp_now = (tst_q == 3'd4) ? desc.sp : SP_HOLD;
    else
      sp_now = (tst_q == 3'd2) ? desc.sp : SP_HOLD;
  end

  msq_regs u_regs (
    .clk(clk), .rst(rst), .din(din), .ir(ir_q), .pc_inc(pc_inc_now),
    .lat(lat_now), .spop(sp_now), .jump(jump_now),
    .pc(pc), .wz(wz), .sp(sp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mcyc_q <= 3'd1; tst_q <= 3'd1; ir_q <= '0; cond_q <= 1'b0; halted_q <= 1'b0;
    end else if (!halted_q) begin
      if (mcyc_q == 3'd1 && tst_q == 3'd3) ir_q   <= din;
      if (mcyc_q == 3'd1 && tst_q == 3'd4) cond_q <= cond_ok;
      if (last_state) begin
        tst_q <= 3'd1;
        if (last_cyc) begin
          mcyc_q   <= 3'd1;
          halted_q <= (kind == K_HLT);
        end else begin
          mcyc_q <= mcyc_q + 3'd1;
        end
      end else begin
        tst_q <= tst_q + 3'd1;
      end
    end
  end

  assign mcyc   = mcyc_q;
  assign tst    = tst_q;
  assign ctype  = desc.ctype;
  assign asrc   = desc.src;
  assign halted = halted_q;

  p_counters_legal_r3: assert property (@(posedge clk) disable iff (rst)
    tst_q >= 3'd1 && tst_q <= 3'd5 && mcyc_q >= 3'd1 && mcyc_q <= 3'd5);
  p_fetch_head_r2: assert property (@(posedge clk) disable iff (rst)
    (mcyc_q == 3'd1) |-> (ctype == 3'(CT_FETCH) && asrc == 2'(AS_PC)));
  p_fetch_step_r2: assert property (@(posedge clk) disable iff (rst)
    (mcyc_q == 3'd1 && tst_q == 3'd2 && !halted_q) |=> pc == AW'($past(pc) + 1'b1));
  p_restart_after_done_r13: assert property (@(posedge clk) disable iff (rst)
    done |=> (mcyc_q == 3'd1 && tst_q == 3'd1));
  p_halt_frozen_r12: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> (halted_q && $stable(pc) && tst_q == 3'd1 && !done));
  p_false_return_short_r10: assert property (@(posedge clk) disable iff (rst)
    (kind == K_RCC && mcyc_q == 3'd1 && tst_q == 3'd5 && !cond_q) |-> done);
endmodule

// File: tb/tb_msq_sequencer.sv
`timescale 1ns/1ps
module tb_msq_sequencer;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  din;
  logic        cond_ok;
  logic [2:0]  mcyc, tst, ctype;
  logic [1:0]  asrc;
  logic [15:0] pc, wz, sp;
  logic        done, halted;
  int total = 0;
  int bad = 0;

  localparam logic [2:0] FE = 3'd0, MR = 3'd1, MW = 3'd2, SR = 3'd3,
                         SW = 3'd4, IR = 3'd5, IW = 3'd6, HA = 3'd7;
  localparam logic [1:0] SPC = 2'd0, SHL = 2'd1, SWZ = 2'd2, SSP = 2'd3;

  always #10 clk = ~clk;

  msq_sequencer dut (
    .clk(clk), .rst(rst), .din(din), .cond_ok(cond_ok), .mcyc(mcyc), .tst(tst),
    .ctype(ctype), .asrc(asrc), .pc(pc), .wz(wz), .sp(sp), .done(done), .halted(halted)
  );

  function automatic logic [14:0] tv(input logic [2:0] a, b, c, d, e);
    return {e, d, c, b, a};
  endfunction
  function automatic logic [9:0] sv(input logic [1:0] a, b, c, d, e);
    return {e, d, c, b, a};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input string req, input string nm, input logic [7:0] op, b2, b3,
                        input logic c, input int exp_ncyc, input int exp_m1,
                        input logic [14:0] et, input logic [9:0] es);
    int ncy = 0, m1n = 0, nst = 0, guard = 0;
    logic [14:0] gt = '0;
    logic [9:0]  gs = '0;
    bit fin = 0;
    cond_ok = c;
    while (!fin && guard < 30) begin
      @(negedge clk);
      guard++;
      nst++;
      din = (mcyc == 3'd1) ? op : (mcyc == 3'd2) ? b2 : b3;
      if (tst == 3'd1 && mcyc >= 3'd1 && mcyc <= 3'd5) begin
        ncy++;
        gt[3*(int'(mcyc)-1) +: 3] = ctype;
        gs[2*(int'(mcyc)-1) +: 2] = asrc;
      end
      if (mcyc == 3'd1) m1n = int'(tst);
      fin = done;
    end
    @(posedge clk); #1;
    chk(req, {nm, " cycle kinds"}, 32'(gt), 32'(et));
    chk(req, {nm, " address sources"}, 32'(gs), 32'(es));
    chk(req, {nm, " cycle count"}, ncy, exp_ncyc);
    chk("R3", {nm, " fetch cycle length"}, m1n, exp_m1);
    chk("R13", {nm, " states until done"}, nst, exp_m1 + 3 * (exp_ncyc - 1));
  endtask

  task automatic t_reset();
    rst = 1'b1; din = 8'h00; cond_ok = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    chk("R1", "reset cycle", mcyc, 1);
    chk("R1", "reset state", tst, 1);
    chk("R1", "reset pc", pc, 0);
    chk("R1", "reset sp", sp, 0);
    chk("R1", "reset wz", wz, 0);
    chk("R1", "reset halted/done", {halted, done}, 0);
  endtask

  task automatic t_simple();
    run_op("R2", "no-op", 8'h00, 8'h00, 8'h00, 0, 1, 4, tv(FE,0,0,0,0), sv(SPC,0,0,0,0));
    chk("R2", "pc after no-op", pc, 16'h0001);
    run_op("R3", "reg move", 8'h41, 8'h00, 8'h00, 0, 1, 5, tv(FE,0,0,0,0), sv(SPC,0,0,0,0));
    chk("R3", "pc after reg move", pc, 16'h0002);
    run_op("R4", "load from HL", 8'h7E, 8'h00, 8'h00, 0, 2, 4, tv(FE,MR,0,0,0), sv(SPC,SHL,0,0,0));
    run_op("R4", "store to HL", 8'h77, 8'h00, 8'h00, 0, 2, 4, tv(FE,MW,0,0,0), sv(SPC,SHL,0,0,0));
    chk("R4", "pc after HL moves", pc, 16'h0004);
    run_op("R5", "immediate reg", 8'h06, 8'h5A, 8'h00, 0, 2, 4, tv(FE,MR,0,0,0), sv(SPC,SPC,0,0,0));
    chk("R5", "pc after immediate", pc, 16'h0006);
    chk("R5", "low byte latched", wz, 16'h005A);
  endtask

  task automatic t_direct();
    run_op("R6", "direct load", 8'h3A, 8'h34, 8'h12, 1, 4, 4, tv(FE,MR,MR,MR,0), sv(SPC,SPC,SPC,SWZ,0));
    chk("R6", "pc after direct load", pc, 16'h0009);
    chk("R5", "byte order direct load", wz, 16'h1234);
    run_op("R6", "direct store", 8'h32, 8'h45, 8'h23, 0, 4, 4, tv(FE,MR,MR,MW,0), sv(SPC,SPC,SPC,SWZ,0));
    chk("R6", "wz after direct store", wz, 16'h2345);
    chk("R6", "pc after direct store", pc, 16'h000C);
  endtask

  task automatic t_jumps();
    run_op("R7", "jump", 8'hC3, 8'h00, 8'h01, 0, 3, 4, tv(FE,MR,MR,0,0), sv(SPC,SPC,SPC,0,0));
    chk("R7", "pc after jump", pc, 16'h0100);
    run_op("R7", "cond jump false", 8'hC2, 8'h00, 8'h02, 0, 3, 4, tv(FE,MR,MR,0,0), sv(SPC,SPC,SPC,0,0));
    chk("R7", "pc after untaken jump", pc, 16'h0103);
    chk("R7", "wz after untaken jump", wz, 16'h0200);
    run_op("R7", "cond jump true", 8'hCA, 8'h00, 8'h03, 1, 3, 4, tv(FE,MR,MR,0,0), sv(SPC,SPC,SPC,0,0));
    chk("R7", "pc after taken jump", pc, 16'h0300);
  endtask

  task automatic t_calls();
    run_op("R8", "call", 8'hCD, 8'h00, 8'h04, 0, 5, 5, tv(FE,MR,MR,SW,SW), sv(SPC,SPC,SPC,SSP,SSP));
    chk("R8", "pc after call", pc, 16'h0400);
    chk("R8", "sp after call", sp, 16'hFFFE);
    run_op("R9", "cond call false", 8'hC4, 8'h00, 8'h05, 0, 3, 5, tv(FE,MR,MR,0,0), sv(SPC,SPC,SPC,0,0));
    chk("R9", "pc after untaken call", pc, 16'h0403);
    chk("R9", "sp after untaken call", sp, 16'hFFFE);
    run_op("R9", "cond call true", 8'hCC, 8'h00, 8'h06, 1, 5, 5, tv(FE,MR,MR,SW,SW), sv(SPC,SPC,SPC,SSP,SSP));
    chk("R9", "pc after taken call", pc, 16'h0600);
    chk("R9", "sp after taken call", sp, 16'hFFFC);
  endtask

  task automatic t_returns();
    run_op("R10", "cond return false", 8'hC0, 8'h00, 8'h00, 0, 1, 5, tv(FE,0,0,0,0), sv(SPC,0,0,0,0));
    chk("R10", "pc after untaken return", pc, 16'h0601);
    chk("R10", "sp after untaken return", sp, 16'hFFFC);
    run_op("R10", "cond return true", 8'hC8, 8'h34, 8'h12, 1, 3, 5, tv(FE,SR,SR,0,0), sv(SPC,SSP,SSP,0,0));
    chk("R10", "pc after taken return", pc, 16'h1234);
    chk("R10", "sp after taken return", sp, 16'hFFFE);
    run_op("R10", "return", 8'hC9, 8'h78, 8'h56, 0, 3, 4, tv(FE,SR,SR,0,0), sv(SPC,SSP,SSP,0,0));
    chk("R10", "pc after return", pc, 16'h5678);
    chk("R10", "sp after return", sp, 16'h0000);
  endtask

  task automatic t_restart_io();
    run_op("R11", "restart 5", 8'hEF, 8'h00, 8'h00, 0, 3, 5, tv(FE,SW,SW,0,0), sv(SPC,SSP,SSP,0,0));
    chk("R11", "restart vector", wz, 16'h0028);
    chk("R11", "pc after restart", pc, 16'h0028);
    chk("R11", "sp after restart", sp, 16'hFFFE);
    run_op("R5", "port in", 8'hDB, 8'h42, 8'h00, 0, 3, 4, tv(FE,MR,IR,0,0), sv(SPC,SPC,SWZ,0,0));
    chk("R5", "port address doubled (in)", wz, 16'h4242);
    run_op("R5", "port out", 8'hD3, 8'h43, 8'h00, 0, 3, 4, tv(FE,MR,IW,0,0), sv(SPC,SPC,SWZ,0,0));
    chk("R5", "port address doubled (out)", wz, 16'h4343);
    chk("R5", "pc after port ops", pc, 16'h002C);
    run_op("R4", "immediate to HL", 8'h36, 8'h99, 8'h00, 0, 3, 4, tv(FE,MR,MW,0,0), sv(SPC,SPC,SHL,0,0));
    chk("R4", "wz after immediate to HL", wz, 16'h4399);
    chk("R4", "pc after immediate to HL", pc, 16'h002E);
  endtask

  task automatic t_halt();
    int dn = 0, moved = 0;
    run_op("R12", "halt", 8'h76, 8'h00, 8'h00, 0, 2, 4, tv(FE,HA,0,0,0), sv(SPC,SPC,0,0,0));
    chk("R12", "halted flag", halted, 1);
    chk("R12", "pc at halt", pc, 16'h002F);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      din = 8'h00;
      if (done) dn++;
      if (pc != 16'h002F || tst != 3'd1 || mcyc != 3'd1) moved++;
    end
    chk("R12", "frozen while halted", moved, 0);
    chk("R13", "no done while halted", dn, 0);
    t_reset();
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_simple();
    t_direct();
    t_jumps();
    t_calls();
    t_returns();
    t_restart_io();
    t_halt();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule